// File: doc/BRIEF.md
# ISA to Multiplexed-Bus Peripheral Bridge

This block is an I/O slave on an ISA-style host bus. It gives the host indirect access to an 8-bit peripheral, such as a CAN controller, whose address and data share one bus. The host first writes a register number to an address port. That number is stored in a pointer latch. A later read or write of a data port starts a multiplexed cycle. The stored number goes onto the shared bus with an address-latch-enable pulse, the address is held for a short time, and then the read or write strobe runs for a fixed count of cycles. The host-side data buffer is steered so that the pointer driver and the peripheral never drive the shared bus at the same time.

The card answers to a block of four ports. The block's base comes from a configuration input compared against host address bits 9 down to 2, and the match is ignored during DMA cycles. Offset 0 is the pointer port, offset 1 is the data port and offset 3 is the reset port. The block also makes the peripheral's active-low reset from three sources: the system reset, a software write to the reset port that is stretched to a fixed width, and a debounced push button.

All host inputs are sampled on the bridge clock. The host wait line is held low until the multiplexed cycle is complete.

Top module: `isaMuxBridge`

## Requirements
- R1: The block reacts to a host access only when `aen` is low and `hostAddr[9:2]` equals `baseSel`. Any other access loads no pointer, starts no peripheral cycle, leaves `perCsN` high and `ioReady` high.
- R2: A host write to offset 0 (`hostAddr[1:0]`=00) stores `hostDataIn` in the pointer latch. This write does not select the peripheral: `perCsN` stays high and `ale` stays low.
- R3: A host read of offset 0 drives the pointer value on `hostDataOut` with `hostDataOe` high, from the cycle after the strobe is sampled.
- R4: A data-port access (offset 01) raises `ale` for ALE_CYC cycles, starting at the first clock edge that sees the access. The pointer is driven on `muxBusOut` with `muxBusOe` high while `ale` is high and for HOLD_CYC cycles after it falls.
- R5: On a data-port read, `perRdN` is low for STRB_CYC cycles right after the hold phase, and `muxBusOe` is low during that time. The byte on `muxBusIn` is then returned on `hostDataOut` with `hostDataOe` high until the host ends the access.
- R6: On a data-port write, `perWrN` is low for STRB_CYC cycles right after the hold phase, with `hostDataIn` driven on `muxBusOut`. The peripheral register named by the pointer receives that byte.
- R7: The read strobe and the pointer driver are never active together. The read and write strobes are never active together. Neither strobe is active while `ale` is high.
- R8: `ioReady` is low from the start of a data-port access until ALE_CYC+HOLD_CYC+STRB_CYC clock edges have passed. It is then high until the host ends the access.
- R9: `perRstN` is low while `sysReset` is high.
- R10: A write to offset 3 drives `perRstN` low for exactly RST_CYC cycles, starting at the first edge that sees the write. The width does not depend on how long the write lasts or on the data byte.
- R11: A press on `btnN` (low) that stays stable for DEB_CYC sampled cycles drives `perRstN` low until the button has been released for as long. Shorter glitches have no effect.
- R12: An access to offset 2 has no effect: the pointer is unchanged, and `perRstN` and `perCsN` stay high.
- R13: `perCsN` is low from the first `ale` cycle until the host ends the data-port access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| sysReset | input | 1 | System reset, active high |
| aen | input | 1 | DMA address enable; high blocks decoding |
| hostAddr | input | 10 | Host I/O address |
| iorN | input | 1 | Host I/O read strobe, active low |
| iowN | input | 1 | Host I/O write strobe, active low |
| hostDataIn | input | 8 | Host write data |
| hostDataOut | output | 8 | Data returned to the host |
| hostDataOe | output | 1 | Host data buffer drive enable |
| ioReady | output | 1 | Host ready; low stretches the cycle |
| baseSel | input | 8 | Base value matched against hostAddr[9:2] |
| btnN | input | 1 | Raw reset push button, active low |
| muxBusIn | input | 8 | Shared bus value driven by the peripheral |
| muxBusOut | output | 8 | Shared bus value driven by the bridge |
| muxBusOe | output | 1 | Bridge drive enable on the shared bus |
| ale | output | 1 | Address latch enable; peripheral captures on fall |
| perCsN | output | 1 | Peripheral chip select, active low |
| perRdN | output | 1 | Peripheral read strobe, active low |
| perWrN | output | 1 | Peripheral write strobe, active low |
| perRstN | output | 1 | Peripheral reset, active low |

## Verification
Inputs change on the falling clock edge, and outputs are read on later falling edges. Call the falling edge where a data-port access is driven sample 0. `ale` is then high at samples 1 through ALE_CYC. The pointer stays on the bus through sample ALE_CYC+HOLD_CYC. The strobe covers the next STRB_CYC samples. `ioReady` and any returned byte first appear at sample ALE_CYC+HOLD_CYC+STRB_CYC+1. The bench compares every sample in that window with this schedule. A reset-port write must give exactly RST_CYC low samples, counted over a window longer than the pulse. Pointer reads are checked one sample after the strobe. Button results are checked after a wait that covers the two synchronizer stages plus DEB_CYC.

// File: rtl/isaBridgePkg.sv
package isaBridgePkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE,
    ST_HOLD,
    ST_STRB,
    ST_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    PORT_PTR   = 2'b00,
    PORT_DATA  = 2'b01,
    PORT_SPARE = 2'b10,
    PORT_RST   = 2'b11
  } portSel_t;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic latchLoad;  // store host byte in pointer latch
    logic ptrRead;    // return pointer to host
    logic ale;        // address latch enable phase
    logic ptrDrive;   // pointer on shared bus
    logic wrDrive;    // host write data on shared bus
    logic rdStb;      // peripheral read strobe
    logic wrStb;      // peripheral write strobe
    logic csActive;   // peripheral selected
    logic rdCapture;  // sample shared bus into read register
    logic rdReturn;   // captured byte to host
  } bridgeStrb_t;

endpackage

// File: rtl/isaBridgeCtrl.sv
module isaBridgeCtrl
  import isaBridgePkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int ALE_CYC  = 2,
  parameter int HOLD_CYC = 1,
  parameter int STRB_CYC = 3
) (
  input  logic              clk,
  input  logic              sysReset,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              aen,
  input  logic              iorN,
  input  logic              iowN,
  input  logic [ADDR_W-3:0] baseSel,
  output bridgeStrb_t       strb,
  output logic              ioReady,
  output logic              rstPortWr
);

  localparam int MAX_PH = (ALE_CYC > HOLD_CYC) ?
                          ((ALE_CYC > STRB_CYC) ? ALE_CYC : STRB_CYC) :
                          ((HOLD_CYC > STRB_CYC) ? HOLD_CYC : STRB_CYC);
  localparam int CNT_W  = $clog2(MAX_PH + 1);

  seqState_t       state;
  logic [CNT_W-1:0] phCnt;
  logic            isRead;

  logic     baseHit;
  portSel_t port;
  logic     rdAct;
  logic     wrAct;
  logic     dataAcc;
  logic     phLast;

  assign baseHit = !aen && (hostAddr[ADDR_W-1:2] == baseSel);
  assign port    = portSel_t'(hostAddr[1:0]);
  assign rdAct   = baseHit && !iorN;
  assign wrAct   = baseHit && !iowN;
  assign dataAcc = (rdAct || wrAct) && (port == PORT_DATA);
  assign phLast  = (phCnt == '0);

  always_ff @(posedge clk or posedge sysReset) begin
    if (sysReset) begin
      state  <= ST_IDLE;
      phCnt  <= '0;
      isRead <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (dataAcc) begin
            state  <= ST_ALE;
            phCnt  <= CNT_W'(ALE_CYC - 1);
            isRead <= rdAct;
          end
        end
        ST_ALE: begin
          if (phLast) begin
            state <= ST_HOLD;
            phCnt <= CNT_W'(HOLD_CYC - 1);
          end else begin
            phCnt <= phCnt - CNT_W'(1);
          end
        end
        ST_HOLD: begin
          if (phLast) begin
            state <= ST_STRB;
            phCnt <= CNT_W'(STRB_CYC - 1);
          end else begin
            phCnt <= phCnt - CNT_W'(1);
          end
        end
        ST_STRB: begin
          if (phLast) begin
            state <= ST_DONE;
          end else begin
            phCnt <= phCnt - CNT_W'(1);
          end
        end
        ST_DONE: begin
          if (!dataAcc) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb           = '0;
    strb.latchLoad = wrAct && (port == PORT_PTR);
    strb.ptrRead   = rdAct && (port == PORT_PTR);
    strb.ale       = (state == ST_ALE);
    strb.ptrDrive  = (state == ST_ALE) || (state == ST_HOLD);
    strb.wrDrive   = (state == ST_STRB) && !isRead;
    strb.rdStb     = (state == ST_STRB) && isRead;
    strb.wrStb     = (state == ST_STRB) && !isRead;
    strb.csActive  = (state != ST_IDLE);
    strb.rdCapture = (state == ST_STRB) && isRead;
    strb.rdReturn  = (state == ST_DONE) && isRead;
  end

  assign ioReady   = !(dataAcc && (state != ST_DONE));
  assign rstPortWr = wrAct && (port == PORT_RST);

endmodule

// File: rtl/isaBridgeDatapath.sv
module isaBridgeDatapath
  import isaBridgePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              sysReset,
  input  bridgeStrb_t       strb,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic [DATA_W-1:0] muxBusIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic [DATA_W-1:0] muxBusOut,
  output logic              muxBusOe,
  output logic              ale,
  output logic              perCsN,
  output logic              perRdN,
  output logic              perWrN
);

  logic [DATA_W-1:0] ptrLatch;
  logic [DATA_W-1:0] rdData;

  always_ff @(posedge clk or posedge sysReset) begin
    if (sysReset) begin
      ptrLatch <= '0;
    end else if (strb.latchLoad) begin
      ptrLatch <= hostDataIn;
    end
  end

  always_ff @(posedge clk or posedge sysReset) begin
    if (sysReset) begin
      rdData <= '0;
    end else if (strb.rdCapture) begin
      rdData <= muxBusIn;
    end
  end

  // Pointer phase and write phase never overlap, read phase drives nothing
  assign muxBusOut   = strb.wrDrive ? hostDataIn : ptrLatch;
  assign muxBusOe    = strb.ptrDrive || strb.wrDrive;

  assign hostDataOut = strb.ptrRead ? ptrLatch : rdData;
  assign hostDataOe  = strb.ptrRead || strb.rdReturn;

  assign ale    = strb.ale;
  assign perCsN = !strb.csActive;
  assign perRdN = !strb.rdStb;
  assign perWrN = !strb.wrStb;

endmodule

// File: rtl/isaBridgeRstGen.sv
module isaBridgeRstGen #(
  parameter int RST_CYC = 20,
  parameter int DEB_CYC = 8
) (
  input  logic clk,
  input  logic sysReset,
  input  logic rstPortWr,
  input  logic btnN,
  output logic perRstN
);

  localparam int SW_W  = $clog2(RST_CYC + 1);
  localparam int DEB_W = $clog2(DEB_CYC + 1);

  logic            wrSeen;
  logic [SW_W-1:0] swCnt;

  always_ff @(posedge clk or posedge sysReset) begin
    if (sysReset) begin
      wrSeen <= 1'b0;
      swCnt  <= '0;
    end else begin
      wrSeen <= rstPortWr;
      if (rstPortWr && !wrSeen) begin
        swCnt <= SW_W'(RST_CYC);
      end else if (swCnt != '0) begin
        swCnt <= swCnt - SW_W'(1);
      end
    end
  end

  logic [1:0]       btnSync;
  logic             btnStable;
  logic [DEB_W-1:0] debCnt;

  always_ff @(posedge clk or posedge sysReset) begin
    if (sysReset) begin
      btnSync   <= 2'b11;
      btnStable <= 1'b1;
      debCnt    <= '0;
    end else begin
      btnSync <= {btnSync[0], btnN};
      if (btnSync[1] == btnStable) begin
        debCnt <= '0;
      end else if (debCnt == DEB_W'(DEB_CYC - 1)) begin
        btnStable <= btnSync[1];
        debCnt    <= '0;
      end else begin
        debCnt <= debCnt + DEB_W'(1);
      end
    end
  end

  assign perRstN = !(sysReset || (swCnt != '0) || !btnStable);

endmodule

// File: rtl/isaMuxBridge.sv
module isaMuxBridge
  import isaBridgePkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int ALE_CYC  = 2,
  parameter int HOLD_CYC = 1,
  parameter int STRB_CYC = 3,
  parameter int RST_CYC  = 20,
  parameter int DEB_CYC  = 8
) (
  input  logic              clk,
  input  logic              sysReset,
  input  logic              aen,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              iorN,
  input  logic              iowN,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic              ioReady,
  input  logic [ADDR_W-3:0] baseSel,
  input  logic              btnN,
  input  logic [DATA_W-1:0] muxBusIn,
  output logic [DATA_W-1:0] muxBusOut,
  output logic              muxBusOe,
  output logic              ale,
  output logic              perCsN,
  output logic              perRdN,
  output logic              perWrN,
  output logic              perRstN
);

  bridgeStrb_t strb;
  logic        rstPortWr;

  isaBridgeCtrl #(
    .ADDR_W  (ADDR_W),
    .ALE_CYC (ALE_CYC),
    .HOLD_CYC(HOLD_CYC),
    .STRB_CYC(STRB_CYC)
  ) ctrl_i (
    .clk      (clk),
    .sysReset (sysReset),
    .hostAddr (hostAddr),
    .aen      (aen),
    .iorN     (iorN),
    .iowN     (iowN),
    .baseSel  (baseSel),
    .strb     (strb),
    .ioReady  (ioReady),
    .rstPortWr(rstPortWr)
  );

  isaBridgeDatapath #(
    .DATA_W(DATA_W)
  ) dp_i (
    .clk        (clk),
    .sysReset   (sysReset),
    .strb       (strb),
    .hostDataIn (hostDataIn),
    .muxBusIn   (muxBusIn),
    .hostDataOut(hostDataOut),
    .hostDataOe (hostDataOe),
    .muxBusOut  (muxBusOut),
    .muxBusOe   (muxBusOe),
    .ale        (ale),
    .perCsN     (perCsN),
    .perRdN     (perRdN),
    .perWrN     (perWrN)
  );

  isaBridgeRstGen #(
    .RST_CYC(RST_CYC),
    .DEB_CYC(DEB_CYC)
  ) rst_i (
    .clk      (clk),
    .sysReset (sysReset),
    .rstPortWr(rstPortWr),
    .btnN     (btnN),
    .perRstN  (perRstN)
  );

endmodule

// File: rtl/isaMuxBridgeChk.sv
module isaMuxBridgeChk #(
  parameter int RST_CYC = 20,
  parameter int DEB_CYC = 8
) (
  input logic clk,
  input logic sysReset,
  input logic ale,
  input logic perCsN,
  input logic perRdN,
  input logic perWrN,
  input logic muxBusOe,
  input logic hostDataOe,
  input logic ioReady,
  input logic perRstN
);

  localparam int MIN_LOW = (RST_CYC < DEB_CYC) ? RST_CYC : DEB_CYC;

  logic [15:0] lowCnt;

  always_ff @(posedge clk) begin
    if (sysReset) begin
      lowCnt <= '0;
    end else if (perRstN) begin
      lowCnt <= '0;
    end else if (lowCnt != 16'hFFFF) begin
      lowCnt <= lowCnt + 16'd1;
    end
  end

  p_ale_no_strobe_r7: assert property (@(posedge clk) disable iff (sysReset)
    ale |-> (perRdN && perWrN));

  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (sysReset)
    !(!perRdN && !perWrN));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (sysReset)
    !perRdN |-> !muxBusOe);

  p_addr_at_ale_fall_r4: assert property (@(posedge clk) disable iff (sysReset)
    $fell(ale) |-> muxBusOe);

  p_cs_covers_ale_r13: assert property (@(posedge clk) disable iff (sysReset)
    ale |-> !perCsN);

  p_return_after_strobe_r5: assert property (@(posedge clk) disable iff (sysReset)
    (hostDataOe && !perCsN) |-> perRdN);

  p_wait_during_strobe_r8: assert property (@(posedge clk) disable iff (sysReset)
    (!perRdN || !perWrN) |-> !ioReady);

  p_reset_width_r10: assert property (@(posedge clk) disable iff (sysReset)
    ($rose(perRstN) && !$past(sysReset)) |-> (lowCnt >= 16'(MIN_LOW)));

endmodule

bind isaMuxBridge isaMuxBridgeChk #(
  .RST_CYC(RST_CYC),
  .DEB_CYC(DEB_CYC)
) chk_i (
  .clk       (clk),
  .sysReset  (sysReset),
  .ale       (ale),
  .perCsN    (perCsN),
  .perRdN    (perRdN),
  .perWrN    (perWrN),
  .muxBusOe  (muxBusOe),
  .hostDataOe(hostDataOe),
  .ioReady   (ioReady),
  .perRstN   (perRstN)
);

// File: tb/isaMuxBridge_tb.sv
`timescale 1ns/1ps
module isaMuxBridge_tb_top;

  localparam int ALE_CYC  = 2;
  localparam int HOLD_CYC = 1;
  localparam int STRB_CYC = 3;
  localparam int RST_CYC  = 20;
  localparam int DEB_CYC  = 8;
  localparam logic [7:0] BASE = 8'hC0;  // ports 0x300..0x303

  logic       clk = 1'b0;
  logic       sysReset;
  logic       aen;
  logic [9:0] hostAddr;
  logic       iorN, iowN;
  logic [7:0] hostDataIn;
  logic [7:0] hostDataOut;
  logic       hostDataOe;
  logic       ioReady;
  logic [7:0] baseSel;
  logic       btnN;
  logic [7:0] muxBusIn;
  logic [7:0] muxBusOut;
  logic       muxBusOe;
  logic       ale, perCsN, perRdN, perWrN, perRstN;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  isaMuxBridge #(
    .ALE_CYC(ALE_CYC), .HOLD_CYC(HOLD_CYC), .STRB_CYC(STRB_CYC),
    .RST_CYC(RST_CYC), .DEB_CYC(DEB_CYC)
  ) dut_i (
    .clk(clk), .sysReset(sysReset), .aen(aen), .hostAddr(hostAddr),
    .iorN(iorN), .iowN(iowN), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe), .ioReady(ioReady),
    .baseSel(baseSel), .btnN(btnN), .muxBusIn(muxBusIn),
    .muxBusOut(muxBusOut), .muxBusOe(muxBusOe), .ale(ale),
    .perCsN(perCsN), .perRdN(perRdN), .perWrN(perWrN), .perRstN(perRstN)
  );

  // Peripheral model: captures address on ALE fall, writes during strobe
  logic [7:0] perRegs [256];
  logic [7:0] capAddr = 8'h00;
  logic       aleQ = 1'b0;

  always @(negedge clk) begin
    if (aleQ && !ale && muxBusOe) capAddr = muxBusOut;
    if (!perWrN && muxBusOe) perRegs[capAddr] = muxBusOut;
    aleQ = ale;
  end

  assign muxBusIn = perRegs[capAddr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostIdle();
    iorN = 1'b1; iowN = 1'b1; aen = 1'b0;
  endtask

  // Single write to a non-data port, held for holdCyc cycles
  task automatic portWrite(input logic [7:0] base, input logic [1:0] off,
                           input logic [7:0] data, input int holdCyc);
    @(negedge clk);
    hostAddr = {base, off}; hostDataIn = data; iowN = 1'b0;
    repeat (holdCyc) @(negedge clk);
    hostIdle();
  endtask

  task automatic readPtr(output logic [7:0] val);
    @(negedge clk);
    hostAddr = {BASE, 2'b00}; iorN = 1'b0;
    @(negedge clk);
    chk(hostDataOe == 1'b1, "R3 ptr oe", hostDataOe, 1);
    val = hostDataOut;
    hostIdle();
  endtask

  task automatic dataAccess(input bit isRd, input logic [7:0] wdata,
                            input logic [7:0] ptr, output logic [7:0] rdata);
    int total = ALE_CYC + HOLD_CYC + STRB_CYC;
    @(negedge clk);
    hostAddr = {BASE, 2'b01}; hostDataIn = wdata;
    if (isRd) iorN = 1'b0; else iowN = 1'b0;
    for (int n = 1; n <= total + 2; n++) begin
      bit expAle, expAddr, expStb, expRdy;
      @(negedge clk);
      expAle  = (n <= ALE_CYC);
      expAddr = (n <= ALE_CYC + HOLD_CYC);
      expStb  = (n > ALE_CYC + HOLD_CYC) && (n <= total);
      expRdy  = (n > total);
      chk(ale == expAle, "R4 ale window", ale, expAle);
      chk(perCsN == 1'b0, "R13 cs low", perCsN, 0);
      chk(ioReady == expRdy, "R8 ready timing", ioReady, expRdy);
      if (expAddr) begin
        chk(muxBusOe && muxBusOut == ptr, "R4 addr driven", muxBusOut, ptr);
      end
      if (isRd) begin
        chk(perRdN == !expStb, "R5 read strobe", perRdN, !expStb);
        chk(perWrN == 1'b1, "R7 no write on read", perWrN, 1);
        if (expStb) chk(muxBusOe == 1'b0, "R7 bus released", muxBusOe, 0);
      end else begin
        chk(perWrN == !expStb, "R6 write strobe", perWrN, !expStb);
        chk(perRdN == 1'b1, "R7 no read on write", perRdN, 1);
        if (expStb) chk(muxBusOe && muxBusOut == wdata, "R6 write data", muxBusOut, wdata);
      end
    end
    rdata = hostDataOut;
    if (isRd) chk(hostDataOe == 1'b1, "R5 return oe", hostDataOe, 1);
    hostIdle();
    @(negedge clk);
    chk(perCsN == 1'b1, "R13 cs released", perCsN, 1);
    chk(hostDataOe == 1'b0, "R5 oe released", hostDataOe, 0);
  endtask

  task automatic tReset();
    repeat (4) @(negedge clk);
    chk(perRstN == 1'b0, "R9 rst during sysReset", perRstN, 0);
    chk(ioReady == 1'b1, "R8 ready idle", ioReady, 1);
    chk(perCsN == 1'b1 && ale == 1'b0, "R13 idle cs", perCsN, 1);
    chk(muxBusOe == 1'b0 && hostDataOe == 1'b0, "R7 idle drivers", muxBusOe, 0);
    sysReset = 1'b0;
    @(negedge clk);
    chk(perRstN == 1'b1, "R9 rst release", perRstN, 1);
  endtask

  task automatic tPointer();
    logic [7:0] v;
    @(negedge clk);
    hostAddr = {BASE, 2'b00}; hostDataIn = 8'h5E; iowN = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(perCsN == 1'b1 && ale == 1'b0, "R2 no select", perCsN, 1);
    end
    hostIdle();
    readPtr(v);
    chk(v == 8'h5E, "R3 ptr readback", v, 8'h5E);
    portWrite(BASE, 2'b00, 8'hA1, 2);
    readPtr(v);
    chk(v == 8'hA1, "R2 ptr overwritten", v, 8'hA1);
  endtask

  task automatic tDecode();
    logic [7:0] v;
    portWrite(8'h55, 2'b00, 8'h77, 2);
    readPtr(v);
    chk(v == 8'hA1, "R1 base mismatch ignored", v, 8'hA1);
    @(negedge clk);
    aen = 1'b1; hostAddr = {BASE, 2'b00}; hostDataIn = 8'h66; iowN = 1'b0;
    repeat (2) @(negedge clk);
    hostIdle();
    readPtr(v);
    chk(v == 8'hA1, "R1 aen write ignored", v, 8'hA1);
    @(negedge clk);
    aen = 1'b1; hostAddr = {BASE, 2'b01}; iorN = 1'b0;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      chk(perCsN == 1'b1 && ioReady == 1'b1, "R1 aen data ignored", perCsN, 1);
    end
    hostIdle();
  endtask

  task automatic tDataPath();
    logic [7:0] r;
    portWrite(BASE, 2'b00, 8'h15, 2);
    dataAccess(1'b0, 8'hA7, 8'h15, r);
    chk(perRegs[8'h15] == 8'hA7, "R6 register written", perRegs[8'h15], 8'hA7);
    dataAccess(1'b1, 8'h00, 8'h15, r);
    chk(r == 8'hA7, "R5 read back written", r, 8'hA7);
    portWrite(BASE, 2'b00, 8'h40, 2);
    dataAccess(1'b1, 8'h00, 8'h40, r);
    chk(r == (8'h40 ^ 8'h5A), "R5 read preset reg", r, 8'h40 ^ 8'h5A);
  endtask

  task automatic countRstLow(input logic [7:0] data, input int holdCyc, input string tag);
    int lows = 0;
    @(negedge clk);
    hostAddr = {BASE, 2'b11}; hostDataIn = data; iowN = 1'b0;
    for (int n = 0; n < RST_CYC + 30; n++) begin
      @(negedge clk);
      if (n == holdCyc - 1) hostIdle();
      if (!perRstN) lows++;
    end
    hostIdle();
    chk(lows == RST_CYC, tag, lows, RST_CYC);
  endtask

  task automatic tResetPort();
    countRstLow(8'h00, 1, "R10 short write width");
    countRstLow(8'hFF, RST_CYC + 20, "R10 long write width");
  endtask

  task automatic tSpare();
    logic [7:0] v;
    @(negedge clk);
    hostAddr = {BASE, 2'b10}; hostDataIn = 8'h99; iowN = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(perRstN == 1'b1 && perCsN == 1'b1, "R12 spare no effect", perRstN, 1);
    end
    hostIdle();
    readPtr(v);
    chk(v == 8'h40, "R12 ptr kept", v, 8'h40);
  endtask

  task automatic tButton();
    bit allHigh = 1'b1;
    @(negedge clk);
    btnN = 1'b0;
    repeat (DEB_CYC / 2) @(negedge clk);
    btnN = 1'b1;
    repeat (DEB_CYC * 4) begin
      @(negedge clk);
      if (!perRstN) allHigh = 1'b0;
    end
    chk(allHigh, "R11 glitch ignored", allHigh, 1);
    btnN = 1'b0;
    repeat (DEB_CYC + 6) @(negedge clk);
    chk(perRstN == 1'b0, "R11 press resets", perRstN, 0);
    repeat (DEB_CYC) @(negedge clk);
    chk(perRstN == 1'b0, "R11 held press", perRstN, 0);
    btnN = 1'b1;
    repeat (DEB_CYC + 6) @(negedge clk);
    chk(perRstN == 1'b1, "R11 release", perRstN, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) perRegs[i] = 8'(i) ^ 8'h5A;
    sysReset = 1'b1; btnN = 1'b1; baseSel = BASE;
    hostAddr = '0; hostDataIn = '0;
    hostIdle();
    tReset();
    tPointer();
    tDecode();
    tDataPath();
    tResetPort();
    tSpare();
    tButton();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule